// File: doc/BRIEF.md
# Programmable Reference Ratio Divider with Test-Mode Control

This block divides the reference clock by a ratio picked from a 5-bit code and emits a one-cycle comparison pulse once per ratio period. The code splits into a 2-bit group field and a 3-bit shift field. The group field picks a base multiplier of 2, 5, 6 or 7, and the shift field picks a power of two that scales the base. Three shift values are not allowed, which leaves 29 usable ratios.

A 3-bit test code sets how the block drives the charge pump. In normal operation the block passes the phase detector's up and down requests through. The test code can also force the pump to sink, force it to source, or turn it off. The same code sets the lock flag reported to status readers, and it picks what drives the general-purpose port: the register bit, the halved feedback-divider signal, or the comparison pulse. In normal operation the lock flag comes from a qualifier. The qualifier needs the phase error to stay inside its window on a run of consecutive comparison pulses. The 2-bit pump current code passes straight through the block.

Top module: `refclk_ratio_divider`

## Requirements
- R1: With group field ratio_code[4:3] = 00, the division ratio is 2 << ratio_code[2:0], which gives 2 to 256.
- R2: With group field 01, 10 or 11, the ratio is 5, 6 or 7 shifted left by ratio_code[2:0], with shift values 0 to 6 only.
- R3: A code with a non-zero group and shift field 111 is illegal. It leaves the ratio at the last legal value, and ratio_err reads 1 from the clock after such a code is applied until the clock after a legal code returns.
- R4: fcomp is high for exactly one cycle per ratio period and is never high on two consecutive cycles. A new ratio code starts to apply only when the current period ends, so the period that is running keeps its old length.
- R5: During and after reset the ratio is 2, and ratio_err, fcomp and the normal-mode lock flag are 0. The first fcomp pulse comes within two cycles of reset release.
- R6: With test_code[1:0] = 00, cp_en is 1 and cp_up and cp_dn follow pd_up and pd_dn.
- R7: test_code[1:0] = 01 forces a sink (cp_dn=1, cp_up=0, cp_en=1), and 10 forces a source (cp_up=1, cp_dn=0, cp_en=1). In both cases lock_flag reads 0.
- R8: test_code[1:0] = 11 turns the pump off (cp_en=0, cp_up=0, cp_dn=0), and lock_flag reads 1.
- R9: port_out follows port_bit when test_code[2]=0. It follows fpd_half for test_code 100, and it follows fcomp for test_code 101, 110 and 111.
- R10: In normal modes, lock_flag rises only after phase_in_win has been 1 on 16 consecutive fcomp pulses. A single pulse with phase_in_win=0 clears the run and drops lock_flag.
- R11: cp_level_out always equals cp_level_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_code | input | 5 | Group field [4:3] and shift field [2:0] |
| test_code | input | 3 | Test-mode code |
| port_bit | input | 1 | Register value for the general-purpose port |
| fpd_half | input | 1 | Feedback divider output, halved |
| pd_up | input | 1 | Phase detector up request |
| pd_dn | input | 1 | Phase detector down request |
| phase_in_win | input | 1 | Phase error inside lock window, sampled on fcomp |
| cp_level_in | input | 2 | Charge-pump current code |
| fcomp | output | 1 | Comparison pulse |
| cp_up | output | 1 | Charge-pump source command |
| cp_dn | output | 1 | Charge-pump sink command |
| cp_en | output | 1 | Charge-pump enable |
| cp_level_out | output | 2 | Current code, passed through |
| lock_flag | output | 1 | Reported lock status |
| port_out | output | 1 | General-purpose port drive |
| ratio_err | output | 1 | Illegal ratio code seen |

## Verification
The pump assertions assume the phase detector never raises pd_up and pd_dn together. The bench holds those two inputs mutually exclusive in every mode. The lock qualifier assumes phase_in_win is only meaningful on the cycle fcomp is high. The bench therefore changes it only on cycles that are not pulses, and counts pulses from a known cleared run. Ratio code changes are made on the falling edge, so the pending ratio is settled well before the next terminal count.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int SHIFT_W = 3;
    localparam int GROUP_W = 2;
    localparam int LOCK_RUN = 16;

    typedef enum logic [1:0] {
        CP_NORMAL = 2'b00,
        CP_SINK   = 2'b01,
        CP_SOURCE = 2'b10,
        CP_OFF    = 2'b11
    } cp_mode_e;

    typedef enum logic [1:0] {
        P0_REG   = 2'b00,
        P0_FPD   = 2'b01,
        P0_FCOMP = 2'b10
    } p0_sel_e;
endpackage

// File: rtl/ratio_decode.sv
module ratio_decode #(
    parameter int SHIFT_W = refdiv_pkg::SHIFT_W,
    parameter int GROUP_W = refdiv_pkg::GROUP_W,
    parameter int CNT_W   = 9
) (
    input  logic [GROUP_W+SHIFT_W-1:0] code,
    output logic [CNT_W-1:0]           ratio,
    output logic                       legal
);
    logic [GROUP_W-1:0] grp;
    logic [SHIFT_W-1:0] sh;
    logic [CNT_W-1:0]   base;

    always_comb begin
        grp   = code[GROUP_W+SHIFT_W-1:SHIFT_W];
        sh    = code[SHIFT_W-1:0];
        base  = (grp == '0) ? CNT_W'(2) : CNT_W'(grp) + CNT_W'(4);
        ratio = base << sh;
        legal = (grp == '0) || (sh != '1);
    end
endmodule

// File: rtl/ref_counter.sv
module ref_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ratio_in,
    input  logic             legal_in,
    output logic             fcomp,
    output logic             ratio_err
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] pend;
        logic             err;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    tc;

    always_comb begin
        st_d = st_q;
        tc   = (st_q.cnt == '0);
        if (legal_in) st_d.pend = ratio_in;
        st_d.err = !legal_in;
        if (tc) begin
            st_d.cnt = st_q.pend - CNT_W'(1);
            st_d.act = st_q.pend;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_W'(1);
            st_q.act  <= CNT_W'(2);
            st_q.pend <= CNT_W'(2);
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fcomp     = tc;
    assign ratio_err = st_q.err;

    // R4: pulses are isolated
    p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fcomp |=> !fcomp);
    // R4: active ratio only changes at the end of a period
    p_swap_at_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> $stable(st_q.act));
    // R3: an illegal code leaves the pending ratio alone
    p_illegal_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_in |=> ($stable(st_q.pend) && ratio_err));
endmodule

// File: rtl/lock_qual.sv
module lock_qual #(
    parameter int RUN_LEN = refdiv_pkg::LOCK_RUN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic in_win,
    output logic locked
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } lk_st_t;

    lk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pulse) begin
            if (!in_win)
                st_d.run = '0;
            else if (st_q.run != RUN_W'(RUN_LEN))
                st_d.run = st_q.run + RUN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = (st_q.run == RUN_W'(RUN_LEN));

    // R10: lock can only be gained on an in-window comparison pulse
    p_lock_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(pulse && in_win));
endmodule

// File: rtl/mode_ctl.sv
module mode_ctl
    import refdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] test_code,
    input  logic       pd_up,
    input  logic       pd_dn,
    input  logic       locked,
    input  logic       fcomp,
    input  logic       fpd_half,
    input  logic       port_bit,
    output logic       cp_up,
    output logic       cp_dn,
    output logic       cp_en,
    output logic       lock_flag,
    output logic       port_out
);
    cp_mode_e mode;
    p0_sel_e  psel;

    always_comb begin
        mode = cp_mode_e'(test_code[1:0]);
        unique case (mode)
            CP_NORMAL: begin cp_en = 1'b1; cp_up = pd_up; cp_dn = pd_dn; lock_flag = locked; end
            CP_SINK:   begin cp_en = 1'b1; cp_up = 1'b0;  cp_dn = 1'b1;  lock_flag = 1'b0;   end
            CP_SOURCE: begin cp_en = 1'b1; cp_up = 1'b1;  cp_dn = 1'b0;  lock_flag = 1'b0;   end
            default:   begin cp_en = 1'b0; cp_up = 1'b0;  cp_dn = 1'b0;  lock_flag = 1'b1;   end
        endcase
        if (!test_code[2])          psel = P0_REG;
        else if (mode == CP_NORMAL) psel = P0_FPD;
        else                        psel = P0_FCOMP;
        unique case (psel)
            P0_FPD:   port_out = fpd_half;
            P0_FCOMP: port_out = fcomp;
            default:  port_out = port_bit;
        endcase
    end

    // R7: never drive source and sink together (inputs assumed exclusive)
    p_pump_dir_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cp_up, cp_dn}));
    // R8: a disabled pump issues no direction command
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_en |-> (!cp_up && !cp_dn && lock_flag));
endmodule

// File: rtl/refclk_ratio_divider.sv
module refclk_ratio_divider
    import refdiv_pkg::*;
#(
    parameter int SHIFT_W  = refdiv_pkg::SHIFT_W,
    parameter int GROUP_W  = refdiv_pkg::GROUP_W,
    parameter int LOCK_RUN = refdiv_pkg::LOCK_RUN
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [GROUP_W+SHIFT_W-1:0] ratio_code,
    input  logic [2:0]                 test_code,
    input  logic                       port_bit,
    input  logic                       fpd_half,
    input  logic                       pd_up,
    input  logic                       pd_dn,
    input  logic                       phase_in_win,
    input  logic [1:0]                 cp_level_in,
    output logic                       fcomp,
    output logic                       cp_up,
    output logic                       cp_dn,
    output logic                       cp_en,
    output logic [1:0]                 cp_level_out,
    output logic                       lock_flag,
    output logic                       port_out,
    output logic                       ratio_err
);
    localparam int MAX_RATIO = 7 << ((1 << SHIFT_W) - 2);
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);

    logic [CNT_W-1:0] ratio;
    logic             legal;
    logic             locked;

    ratio_decode #(.SHIFT_W(SHIFT_W), .GROUP_W(GROUP_W), .CNT_W(CNT_W)) u_dec (
        .code (ratio_code),
        .ratio(ratio),
        .legal(legal)
    );

    ref_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_in (ratio),
        .legal_in (legal),
        .fcomp    (fcomp),
        .ratio_err(ratio_err)
    );

    lock_qual #(.RUN_LEN(LOCK_RUN)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (fcomp),
        .in_win(phase_in_win),
        .locked(locked)
    );

    mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_code(test_code),
        .pd_up    (pd_up),
        .pd_dn    (pd_dn),
        .locked   (locked),
        .fcomp    (fcomp),
        .fpd_half (fpd_half),
        .port_bit (port_bit),
        .cp_up    (cp_up),
        .cp_dn    (cp_dn),
        .cp_en    (cp_en),
        .lock_flag(lock_flag),
        .port_out (port_out)
    );

    assign cp_level_out = cp_level_in;
endmodule

// File: tb/refclk_ratio_divider_tb_top.sv
module refclk_ratio_divider_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ratio_code = '0;
    logic [2:0] test_code = '0;
    logic       port_bit = 1'b0, fpd_half = 1'b0, pd_up = 1'b0, pd_dn = 1'b0;
    logic       phase_in_win = 1'b0;
    logic [1:0] cp_level_in = '0;
    logic       fcomp, cp_up, cp_dn, cp_en, lock_flag, port_out, ratio_err;
    logic [1:0] cp_level_out;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    refclk_ratio_divider dut_i (
        .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .test_code(test_code),
        .port_bit(port_bit), .fpd_half(fpd_half), .pd_up(pd_up), .pd_dn(pd_dn),
        .phase_in_win(phase_in_win), .cp_level_in(cp_level_in), .fcomp(fcomp),
        .cp_up(cp_up), .cp_dn(cp_dn), .cp_en(cp_en), .cp_level_out(cp_level_out),
        .lock_flag(lock_flag), .port_out(port_out), .ratio_err(ratio_err)
    );

    localparam int NV = 10;
    localparam logic [4:0] V_CODE [NV] = '{5'b00000, 5'b00011, 5'b00111, 5'b01000, 5'b01110,
                                           5'b10010, 5'b10110, 5'b11000, 5'b11110, 5'b11011};
    localparam int V_RATIO [NV] = '{2, 16, 256, 5, 320, 24, 384, 7, 448, 56};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        int k = 0;
        do begin @(negedge clk); k++; end while (!fcomp && k < 2000);
        if (!fcomp) chk("pulse timeout", 0, 1);
    endtask

    task automatic measure(output int n);
        wait_pulse();
        n = 0;
        do begin @(negedge clk); n++; end while (!fcomp && n < 2000);
    endtask

    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int per;
        repeat (3) @(negedge clk);
        // R5 reset state
        chk("R5 fcomp in reset", fcomp, 0);
        chk("R5 ratio_err in reset", ratio_err, 0);
        chk("R5 lock_flag in reset", lock_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 first pulse", fcomp, 1);
        measure(per);
        chk("R5 default ratio", per, 2);

        // R1 R2 vector walk
        for (int i = 0; i < NV; i++) begin
            ratio_code = V_CODE[i];
            wait_pulse(); wait_pulse();
            measure(per);
            chk(V_CODE[i][4:3] == 2'b00 ? "R1 ratio" : "R2 ratio", per, V_RATIO[i]);
        end

        // R4 change mid-period keeps current length
        ratio_code = 5'b00111;
        wait_pulse(); wait_pulse();
        repeat (10) @(negedge clk);
        ratio_code = 5'b00000;
        per = 10;
        do begin @(negedge clk); per++; end while (!fcomp && per < 2000);
        chk("R4 no runt", per, 256);
        measure(per);
        chk("R4 new ratio after tc", per, 2);

        // R3 illegal code
        ratio_code = 5'b01001;
        wait_pulse(); wait_pulse();
        ratio_code = 5'b01111;
        @(negedge clk);
        chk("R3 err raised", ratio_err, 1);
        wait_pulse();
        measure(per);
        chk("R3 ratio held", per, 10);
        ratio_code = 5'b11111;
        measure(per);
        chk("R3 ratio held group3", per, 10);
        ratio_code = 5'b00001;
        @(negedge clk);
        chk("R3 err cleared", ratio_err, 0);

        // R10 lock qualification at ratio 2
        ratio_code = 5'b00000;
        wait_pulse(); wait_pulse();
        phase_in_win = 1'b0;
        wait_pulse(); @(negedge clk);
        phase_in_win = 1'b1;
        for (int p = 0; p < 15; p++) wait_pulse();
        @(negedge clk);
        chk("R10 not locked after 15", lock_flag, 0);
        wait_pulse(); @(negedge clk);
        chk("R10 locked after 16", lock_flag, 1);
        phase_in_win = 1'b0;
        wait_pulse(); @(negedge clk);
        chk("R10 miss drops lock", lock_flag, 0);
        phase_in_win = 1'b1;
        for (int p = 0; p < 16; p++) wait_pulse();
        @(negedge clk);
        chk("R10 relock", lock_flag, 1);

        // R6 normal pump
        test_code = 3'b000; pd_up = 1'b1; pd_dn = 1'b0; #1;
        chk("R6 en", cp_en, 1); chk("R6 up", cp_up, 1); chk("R6 dn", cp_dn, 0);
        pd_up = 1'b0; pd_dn = 1'b1; #1;
        chk("R6 up follow", cp_up, 0); chk("R6 dn follow", cp_dn, 1);
        pd_dn = 1'b0;
        // R7 forced modes (lock is held at 1 here)
        test_code = 3'b001; pd_up = 1'b1; #1;
        chk("R7 sink dn", cp_dn, 1); chk("R7 sink up", cp_up, 0);
        chk("R7 sink en", cp_en, 1); chk("R7 sink flag", lock_flag, 0);
        test_code = 3'b010; pd_up = 1'b0; pd_dn = 1'b1; #1;
        chk("R7 source up", cp_up, 1); chk("R7 source dn", cp_dn, 0);
        chk("R7 source flag", lock_flag, 0);
        pd_dn = 1'b0;
        // R8 disabled pump
        phase_in_win = 1'b0; test_code = 3'b000;
        wait_pulse(); @(negedge clk);
        test_code = 3'b011; pd_up = 1'b1; #1;
        chk("R8 en", cp_en, 0); chk("R8 up", cp_up, 0); chk("R8 flag", lock_flag, 1);
        pd_up = 1'b0;

        // R9 port mux
        test_code = 3'b011; port_bit = 1'b1; fpd_half = 1'b0; #1;
        chk("R9 reg bit", port_out, 1);
        test_code = 3'b100; #1;
        chk("R9 fpd low", port_out, 0);
        fpd_half = 1'b1; port_bit = 1'b0; #1;
        chk("R9 fpd high", port_out, 1);
        test_code = 3'b110; fpd_half = 1'b0;
        wait_pulse();
        chk("R9 fcomp high", port_out, 1);
        @(negedge clk);
        chk("R9 fcomp low", port_out, 0);
        test_code = 3'b000; port_bit = 1'b0; #1;
        chk("R9 reg bit low", port_out, 0);

        // R11 passthrough
        for (int c = 0; c < 4; c++) begin
            cp_level_in = 2'(c); #1;
            chk("R11 level", cp_level_out, c);
        end

        // R5 reset mid-run
        ratio_code = 5'b01111;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R5 err cleared by reset", ratio_err, 0);
        ratio_code = 5'b00000;
        rst_n = 1'b1;
        measure(per);
        chk("R5 ratio after reset", per, 2);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule